// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block stores a set of alarm targets for a real-time clock: second, minute, hour, day of month, month and a three-digit year, all in BCD, together with a control word that selects which targets take part and a global alarm gate. The calendar counter is a separate block. It presents the current BCD time on the calendar inputs and pulses a one-second strobe in the cycle where the newly advanced time is valid.

In each strobe cycle the comparator checks every selected field against the current value. If any one selected field matches, a sticky pending flag is set on the next clock edge. The alarm interrupt follows that flag. Software reads the targets, the control word and the status through a small register port, and clears the flag by writing a one to its status bit.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, every alarm target, the control word and the pending flag read as zero, and alarm_irq is low.
- R2: Register selects are 0 status, 1 control, 2 second, 3 minute, 4 hour, 5 day, 6 month and 7 year. Writes are masked before storage: control to bits [6:0], second and minute to 7 bits, hour and day to 6 bits, month to 5 bits, year to 12 bits. Reads return the stored value zero-extended.
- R3: Comparison happens only in a cycle where sec_tick is high. A resulting match sets the pending flag at the following clock edge.
- R4: Control bits 0 through 5 enable comparison of second, minute, hour, day, month and year in that order. A field whose bit is clear never causes a match.
- R5: Control bit 6 is a global gate. While it is clear, no comparison can set the pending flag.
- R6: Enabled fields are combined with OR. One enabled matching field fires the alarm, even when other enabled fields differ.
- R7: The year target is compared as three BCD digits: the hundreds digit in bits [11:8], tens and units in bits [7:0].
- R8: The month target is compared with cur_mon exactly as presented, a 1-based BCD month (8'h01 is January, 8'h12 is December).
- R9: Status bit 1 reads the pending flag, which stays set until cleared. Writing status with bit 1 set clears it. Writing status with bit 1 clear has no effect.
- R10: If a match and a clearing write occur in the same cycle, the flag stays set.
- R11: alarm_irq equals the pending flag in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 16 | Combinational read data |
| sec_tick | input | 1 | One-second update strobe; current time is already advanced |
| cur_sec | input | 8 | Current second, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, 1-based BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
Directed cases drive one enabled field at a time, so a wrong enable-bit order or a swapped field shows up as a missing or unexpected fire. Mixed cases with one enabled field matching and another enabled field differing separate an OR combination from an AND. Cases with a match but no strobe, or with the global gate off, separate gated comparison from free-running comparison. Year values that differ only in the hundreds digit, month 12 against 11, and a clear in the same cycle as a match cover the remaining corners. A seeded random phase then mixes writes, clears and strobes, with current values often equal to the targets, and checks the interrupt and status against a bench model in every cycle.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int NUM_FLD  = 6;
    localparam int FLD_W    = 12;
    localparam int CTRL_W   = 7;
    localparam int GLB_BIT  = 6;
    localparam int PEND_BIT = 1;
    localparam int SEL_FLD0 = 2;

    typedef enum logic [2:0] {
        SEL_STAT = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_SEC  = 3'd2,
        SEL_MIN  = 3'd3,
        SEL_HOUR = 3'd4,
        SEL_DAY  = 3'd5,
        SEL_MON  = 3'd6,
        SEL_YEAR = 3'd7
    } reg_sel_e;

    typedef logic [FLD_W-1:0] fld_t;

    typedef struct packed {
        logic [CTRL_W-1:0]        ctrl;
        fld_t [NUM_FLD-1:0]       fld;
    } alarm_cfg_t;

    function automatic fld_t fld_mask(input int idx);
        case (idx)
            0, 1:    return 12'h07F;
            2, 3:    return 12'h03F;
            4:       return 12'h01F;
            default: return 12'hFFF;
        endcase
    endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output alarm_cfg_t    cfg
);
    logic [CTRL_W-1:0] ctrl_q;
    fld_t              fld_q [NUM_FLD];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_sel == SEL_CTRL) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
        localparam logic [2:0] MY_SEL = 3'(SEL_FLD0 + i);
        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q[i] <= '0;
            end else if (wr_en && wr_sel == MY_SEL) begin
                fld_q[i] <= wr_data[FLD_W-1:0] & fld_mask(i);
            end
        end
    end

    always_comb begin
        cfg.ctrl = ctrl_q;
        for (int k = 0; k < NUM_FLD; k++) begin
            cfg.fld[k] = fld_q[k];
        end
    end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import cal_alarm_pkg::*;
(
    input  alarm_cfg_t         cfg,
    input  fld_t [NUM_FLD-1:0] cur,
    output logic               fire
);
    logic [NUM_FLD-1:0] hit;

    for (genvar i = 0; i < NUM_FLD; i++) begin : g_hit
        assign hit[i] = cfg.ctrl[i] && (cfg.fld[i] == cur[i]);
    end

    assign fire = cfg.ctrl[GLB_BIT] && (|hit);
endmodule

// File: rtl/alarm_pend.sv
module alarm_pend (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (set) begin
            pend <= 1'b1;
        end else if (clr) begin
            pend <= 1'b0;
        end
    end

    AST_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        set |=> pend); // R10
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pend); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend); // R9
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    input  logic          sec_tick,
    input  logic [7:0]    cur_sec,
    input  logic [7:0]    cur_min,
    input  logic [7:0]    cur_hour,
    input  logic [7:0]    cur_mday,
    input  logic [7:0]    cur_mon,
    input  logic [11:0]   cur_year,
    output logic          alarm_irq
);
    alarm_cfg_t         cfg;
    fld_t [NUM_FLD-1:0] cur;
    logic               fire;
    logic               pend_set;
    logic               pend_clr;
    logic               pend;

    assign cur[0] = FLD_W'(cur_sec);
    assign cur[1] = FLD_W'(cur_min);
    assign cur[2] = FLD_W'(cur_hour);
    assign cur[3] = FLD_W'(cur_mday);
    assign cur[4] = FLD_W'(cur_mon);
    assign cur[5] = cur_year;

    alarm_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    alarm_cmp u_cmp (
        .cfg  (cfg),
        .cur  (cur),
        .fire (fire)
    );

    assign pend_set = sec_tick && fire;
    assign pend_clr = wr_en && (wr_sel == SEL_STAT) && wr_data[PEND_BIT];

    alarm_pend u_pend (
        .clk  (clk),
        .rst  (rst),
        .set  (pend_set),
        .clr  (pend_clr),
        .pend (pend)
    );

    assign alarm_irq = pend;

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_STAT: rd_data[PEND_BIT]     = pend;
            SEL_CTRL: rd_data[CTRL_W-1:0]   = cfg.ctrl;
            SEL_SEC:  rd_data[FLD_W-1:0]    = cfg.fld[0];
            SEL_MIN:  rd_data[FLD_W-1:0]    = cfg.fld[1];
            SEL_HOUR: rd_data[FLD_W-1:0]    = cfg.fld[2];
            SEL_DAY:  rd_data[FLD_W-1:0]    = cfg.fld[3];
            SEL_MON:  rd_data[FLD_W-1:0]    = cfg.fld[4];
            default:  rd_data[FLD_W-1:0]    = cfg.fld[5];
        endcase
    end

    AST_NO_TICK_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !alarm_irq) |=> !alarm_irq); // R3
    AST_GLB_GATE: assert property (@(posedge clk) disable iff (rst)
        (!cfg.ctrl[GLB_BIT] && !alarm_irq) |=> !alarm_irq); // R5
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_irq) |-> $past(sec_tick)); // R3
endmodule

// File: tb/cal_alarm_match_bench.sv
`timescale 1ns/1ps
module cal_alarm_match_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic [2:0]  rd_sel;
    logic [15:0] rd_data;
    logic        sec_tick;
    logic [7:0]  cur_sec, cur_min, cur_hour, cur_mday, cur_mon;
    logic [11:0] cur_year;
    logic        alarm_irq;

    int n_tests = 0;
    int n_fail  = 0;

    logic [6:0]  m_ctrl;
    logic [11:0] m_fld [6];
    logic        m_pend;

    always #2.5 clk = ~clk;

    cal_alarm_match u_cal_alarm_match (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_mday(cur_mday), .cur_mon(cur_mon), .cur_year(cur_year),
        .alarm_irq(alarm_irq)
    );

    function automatic logic [11:0] bmask(input int i);
        if (i < 2) return 12'h07F;
        if (i < 4) return 12'h03F;
        if (i == 4) return 12'h01F;
        return 12'hFFF;
    endfunction

    function automatic logic [11:0] cur_of(input int i);
        case (i)
            0: return {4'h0, cur_sec};
            1: return {4'h0, cur_min};
            2: return {4'h0, cur_hour};
            3: return {4'h0, cur_mday};
            4: return {4'h0, cur_mon};
            default: return cur_year;
        endcase
    endfunction

    function automatic logic exp_fire();
        logic any = 1'b0;
        for (int i = 0; i < 6; i++)
            if (m_ctrl[i] && m_fld[i] == cur_of(i)) any = 1'b1;
        return m_ctrl[6] && any;
    endfunction

    function automatic logic [15:0] exp_read(input logic [2:0] s);
        if (s == 0) return {14'h0, m_pend, 1'b0};
        if (s == 1) return {9'h0, m_ctrl};
        return {4'h0, m_fld[s-2]};
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = 0; sec_tick = 0;
    endtask

    // one clock: inputs already driven; update model, then check irq after edge
    task automatic step(input string req);
        logic f;
        @(posedge clk);
        if (rst) begin
            m_ctrl = 0; m_pend = 0;
            for (int i = 0; i < 6; i++) m_fld[i] = 0;
        end else begin
            f = sec_tick && exp_fire();
            if (wr_en) begin
                if (wr_sel == 1) m_ctrl = wr_data[6:0];
                else if (wr_sel >= 2) m_fld[wr_sel-2] = wr_data[11:0] & bmask(int'(wr_sel) - 2);
            end
            if (f) m_pend = 1;
            else if (wr_en && wr_sel == 0 && wr_data[1]) m_pend = 0;
        end
        @(negedge clk);
        check({15'h0, alarm_irq}, {15'h0, m_pend}, req);
        idle();
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d, input string req);
        wr_en = 1; wr_sel = s; wr_data = d;
        step(req);
    endtask

    task automatic tick(input string req);
        sec_tick = 1;
        step(req);
    endtask

    task automatic rd(input logic [2:0] s, input string req);
        rd_sel = s;
        #0.5;
        check(rd_data, exp_read(s), req);
    endtask

    task automatic set_cur(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] mo, input logic [11:0] y);
        cur_sec = s; cur_min = mi; cur_hour = h; cur_mday = d; cur_mon = mo; cur_year = y;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed = 32'h5EED;
        void'($urandom(seed));
        idle(); rd_sel = 0;
        set_cur(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
        rst = 1;
        @(negedge clk);
        step("R1"); step("R1");
        rst = 0;
        // R1 reset state
        for (int s = 0; s < 8; s++) rd(3'(s), "R1");
        check({15'h0, alarm_irq}, 16'h0, "R1");

        // R2 masking
        for (int s = 1; s < 8; s++) wr(3'(s), 16'hFFFF, "R2");
        for (int s = 1; s < 8; s++) rd(3'(s), "R2");
        check(rd_data, 16'h0FFF, "R2");
        rd(3'd6, "R2"); check(rd_data, 16'h001F, "R2");

        // R4 second only
        wr(3'd2, 16'h0030, "R4"); wr(3'd1, 16'h0041, "R4");
        set_cur(8'h30, 8'h59, 8'h23, 8'h15, 8'h06, 12'h124);
        // R3: no tick, no fire
        step("R3");
        check({15'h0, alarm_irq}, 16'h0, "R3");
        tick("R4");
        check({15'h0, alarm_irq}, 16'h1, "R4");
        rd(3'd0, "R9");
        // R9 write zero does nothing, write one clears
        wr(3'd0, 16'h0001, "R9"); check({15'h0, alarm_irq}, 16'h1, "R9");
        wr(3'd0, 16'h0002, "R9"); check({15'h0, alarm_irq}, 16'h0, "R9");
        // R4 minute enabled only, second matching -> no fire
        wr(3'd3, 16'h0010, "R4"); wr(3'd1, 16'h0042, "R4");
        tick("R4"); check({15'h0, alarm_irq}, 16'h0, "R4");
        // R6 OR: sec matches, min differs, both enabled
        wr(3'd1, 16'h0043, "R6");
        tick("R6"); check({15'h0, alarm_irq}, 16'h1, "R6");
        // R10 same-cycle clear and match
        wr_en = 1; wr_sel = 0; wr_data = 16'h0002; sec_tick = 1;
        step("R10"); check({15'h0, alarm_irq}, 16'h1, "R10");
        wr(3'd0, 16'h0002, "R9");
        // R5 global gate off
        wr(3'd1, 16'h0001, "R5");
        tick("R5"); check({15'h0, alarm_irq}, 16'h0, "R5");
        // R7 year hundreds digit
        wr(3'd7, 16'h0123, "R7"); wr(3'd1, 16'h0060, "R7");
        set_cur(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h023);
        tick("R7"); check({15'h0, alarm_irq}, 16'h0, "R7");
        cur_year = 12'h123;
        tick("R7"); check({15'h0, alarm_irq}, 16'h1, "R7");
        wr(3'd0, 16'h0002, "R9");
        // R8 month as presented
        wr(3'd6, 16'h0012, "R8"); wr(3'd1, 16'h0050, "R8");
        cur_mon = 8'h11;
        tick("R8"); check({15'h0, alarm_irq}, 16'h0, "R8");
        cur_mon = 8'h12;
        tick("R8"); check({15'h0, alarm_irq}, 16'h1, "R8");
        wr(3'd0, 16'h0002, "R9");

        // random phase, irq checked each step (R11), status read (R9)
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 9);
            if (r < 3) begin
                wr_en = 1; wr_sel = 3'($urandom_range(0, 7));
                wr_data = 16'($urandom);
                if (wr_sel == 1 && $urandom_range(0, 1) == 1) wr_data[6] = 1'b1;
            end
            sec_tick = ($urandom_range(0, 2) == 0);
            set_cur(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                    8'($urandom), 12'($urandom));
            for (int i = 0; i < 6; i++) begin
                if ($urandom_range(0, 3) == 0) begin
                    case (i)
                        0: cur_sec  = m_fld[0][7:0];
                        1: cur_min  = m_fld[1][7:0];
                        2: cur_hour = m_fld[2][7:0];
                        3: cur_mday = m_fld[3][7:0];
                        4: cur_mon  = m_fld[4][7:0];
                        default: cur_year = m_fld[5];
                    endcase
                end
            end
            step("R11");
            rd(3'($urandom_range(0, 7)), "R2");
            rd(3'd0, "R9");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule